// File: doc/BRIEF.md
# Parallel ADC Handshake Controller

This block runs one conversion cycle on a single-channel, 8-bit parallel converter that has active-low control pins. When a start request arrives, the controller asserts chip select and holds the write strobe low for a set number of clocks. It then releases the strobe, and that rising edge starts the conversion. The controller waits for the converter to pull its completion line low. It then asserts chip select with the read strobe, which puts the conversion result on the data pins. After a set access delay it captures the byte, releases both strobes and marks the result with a one-cycle valid pulse.

A conversion can take up to about 100 µs. The wait for completion is therefore bounded by a cycle limit that must cover that time at the system clock. If the completion line never falls, the controller gives up, raises a one-cycle error pulse and returns to idle. The completion line is asynchronous to the system clock, so it passes through a synchronizer before the state machine uses it. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `adc_hs_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the idle state after reset, `adc_cs_n_o`, `adc_wr_n_o` and `adc_rd_n_o` are high and `result_vld_o`, `busy_o` and `timeout_err_o` are low. Reset asserts asynchronously and is released through a two-stage synchronizer.
- R2: An accepted start drives `adc_wr_n_o` low for exactly `WR_LOW_CYC` cycles. It is then high for one cycle with `adc_cs_n_o` still low, and that rising write edge starts the conversion.
- R3: `adc_cs_n_o` is low in every cycle in which `adc_wr_n_o` or `adc_rd_n_o` is low.
- R4: After `adc_int_n_i` is seen low, passed through a two-stage synchronizer, `adc_rd_n_o` is driven low for exactly `RD_ACC_CYC` cycles.
- R5: `result_o` takes the value present on `adc_data_i` in the last cycle in which `adc_rd_n_o` is low. It holds that value until the next capture.
- R6: `result_vld_o` is high for exactly one cycle per conversion. That cycle is the one in which `adc_rd_n_o` and `adc_cs_n_o` return high.
- R7: `busy_o` is high from the cycle after a start is accepted up to and including the valid or error cycle, and low in idle.
- R8: A `start_i` that is high while `busy_o` is high is ignored. It does not cause a second write strobe.
- R9: The wait for completion accepts up to `TIMEOUT_CYC` cycles. The default of 6000 cycles, which is 120 µs at 50 MHz, covers a 100 µs conversion.
- R10: If the synchronized completion line stays high for `TIMEOUT_CYC` cycles, `timeout_err_o` pulses for one cycle. In that case no read strobe and no valid pulse occur, and the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled in idle |
| adc_int_n_i | input | 1 | Converter completion line, active low, asynchronous |
| adc_data_i | input | 8 | Converter data bus |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_wr_n_o | output | 1 | Converter write/start strobe, active low |
| adc_rd_n_o | output | 1 | Converter read strobe, active low |
| result_o | output | 8 | Last captured conversion result |
| result_vld_o | output | 1 | One-cycle marker for a new result |
| busy_o | output | 1 | Conversion in progress |
| timeout_err_o | output | 1 | One-cycle pulse when the completion wait expires |

## Verification
The assertions assume two things about the converter. It lowers its completion line only after a write rising edge, and it keeps the data bus stable for the whole read-low window. The bench's converter model follows both rules. It starts its countdown only on a write rising edge seen with chip select low, and it drives the chosen byte for as long as read and chip select are both low. Outside that window the model drives a decoy byte, so a capture at the wrong time is caught. Timeout is exercised by turning off the model's completion response.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WR_LOW = 3'd1,
    ST_WR_REL = 3'd2,
    ST_WAIT   = 3'd3,
    ST_RD_LOW = 3'd4,
    ST_DONE   = 3'd5,
    ST_ERR    = 3'd6
  } hs_state_e;

  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic rd_n;
    logic vld;
    logic busy;
    logic err;
  } hs_pins_t;

  function automatic hs_pins_t decode_pins(hs_state_e st);
    hs_pins_t p;
    p = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, vld: 1'b0, busy: 1'b1, err: 1'b0};
    case (st)
      ST_IDLE:   p.busy = 1'b0;
      ST_WR_LOW: begin p.cs_n = 1'b0; p.wr_n = 1'b0; end
      ST_WR_REL: p.cs_n = 1'b0;
      ST_RD_LOW: begin p.cs_n = 1'b0; p.rd_n = 1'b0; end
      ST_DONE:   p.vld = 1'b1;
      ST_ERR:    p.err = 1'b1;
      default:   ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/adc_sync_chain.sv
module adc_sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) ff_q <= RST_VAL;
        else         ff_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2 / R4 / R9: the controller never asks an expired timer to count further
  p_tmr_nowrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !zero);

endmodule

// File: rtl/adc_hs_fsm.sv
module adc_hs_fsm
  import adc_hs_pkg::*;
#(
  parameter int WR_LOW_CYC  = 4,
  parameter int RD_ACC_CYC  = 3,
  parameter int TIMEOUT_CYC = 6000,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              int_s_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              tmr_dec,
  output logic              cs_n_o,
  output logic              wr_n_o,
  output logic              rd_n_o,
  output logic [DATA_W-1:0] result_o,
  output logic              vld_o,
  output logic              busy_o,
  output logic              err_o
);

  localparam logic [CNT_W-1:0] WR_V = CNT_W'(WR_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] RD_V = CNT_W'(RD_ACC_CYC - 1);
  localparam logic [CNT_W-1:0] TO_V = CNT_W'(TIMEOUT_CYC - 1);

  hs_state_e         st_q, st_d;
  hs_pins_t          pins_q, pins_d;
  logic              cap_en;
  logic [DATA_W-1:0] res_q;

  // next-state process
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    cap_en   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d     = ST_WR_LOW;
          tmr_load = 1'b1;
          tmr_val  = WR_V;
        end
      end
      ST_WR_LOW: begin
        if (tmr_zero) st_d = ST_WR_REL;
        else          tmr_dec = 1'b1;
      end
      ST_WR_REL: begin
        st_d     = ST_WAIT;
        tmr_load = 1'b1;
        tmr_val  = TO_V;
      end
      ST_WAIT: begin
        if (!int_s_n) begin
          st_d     = ST_RD_LOW;
          tmr_load = 1'b1;
          tmr_val  = RD_V;
        end else if (tmr_zero) begin
          st_d = ST_ERR;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_RD_LOW: begin
        if (tmr_zero) begin
          st_d   = ST_DONE;
          cap_en = 1'b1;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      ST_ERR:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    pins_d = decode_pins(st_d);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pins_q <= decode_pins(ST_IDLE);
    end else begin
      st_q   <= st_d;
      pins_q <= pins_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (cap_en) res_q <= data_i;
  end

  assign cs_n_o   = pins_q.cs_n;
  assign wr_n_o   = pins_q.wr_n;
  assign rd_n_o   = pins_q.rd_n;
  assign vld_o    = pins_q.vld;
  assign busy_o   = pins_q.busy;
  assign err_o    = pins_q.err;
  assign result_o = res_q;

  p_cs_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n_o || !rd_n_o) |-> !cs_n_o);

  p_wr_rise_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n_o) |-> !cs_n_o);

  p_vld_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);

  p_vld_after_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ($past(!rd_n_o) && rd_n_o && cs_n_o));

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cs_n_o && wr_n_o && rd_n_o && !vld_o && !err_o));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !vld_o && !err_o) |=> busy_o);

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!vld_o && rd_n_o && $stable(result_o)));

  p_res_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |=> ($stable(result_o) || vld_o));

endmodule

// File: rtl/adc_hs_ctrl.sv
module adc_hs_ctrl #(
  parameter int WR_LOW_CYC  = 4,
  parameter int RD_ACC_CYC  = 3,
  parameter int TIMEOUT_CYC = 6000,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              adc_int_n_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_cs_n_o,
  output logic              adc_wr_n_o,
  output logic              adc_rd_n_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_vld_o,
  output logic              busy_o,
  output logic              timeout_err_o
);

  localparam int MAX_A = (WR_LOW_CYC > RD_ACC_CYC) ? WR_LOW_CYC : RD_ACC_CYC;
  localparam int MAX_C = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             rst_s_n;
  logic             int_s_n;
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  adc_sync_chain #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_s_n)
  );

  adc_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_int_sync (
    .clk(clk), .arst_n(rst_s_n), .d(adc_int_n_i), .q(int_s_n)
  );

  adc_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_s_n), .load(tmr_load), .load_val(tmr_val),
    .dec(tmr_dec), .zero(tmr_zero)
  );

  adc_hs_fsm #(
    .WR_LOW_CYC(WR_LOW_CYC), .RD_ACC_CYC(RD_ACC_CYC), .TIMEOUT_CYC(TIMEOUT_CYC),
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .start_i(start_i), .int_s_n(int_s_n),
    .data_i(adc_data_i), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .tmr_dec(tmr_dec), .cs_n_o(adc_cs_n_o),
    .wr_n_o(adc_wr_n_o), .rd_n_o(adc_rd_n_o), .result_o(result_o),
    .vld_o(result_vld_o), .busy_o(busy_o), .err_o(timeout_err_o)
  );

endmodule

// File: tb/sim_adc_hs_ctrl.sv
module sim_adc_hs_ctrl;

  localparam int WR_LOW_CYC  = 4;
  localparam int RD_ACC_CYC  = 3;
  localparam int TIMEOUT_CYC = 6000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       adc_int_n = 1'b1;
  logic [7:0] adc_data;
  logic       cs_n, wr_n, rd_n, vld, busy, err;
  logic [7:0] result;

  logic [7:0] data_val = 8'h00;
  int         conv_cycles = 10;
  logic       adc_en = 1'b1;

  int checks = 0, errors = 0;
  int wr_run = 0, wr_last = 0, wr_pulses = 0;
  int rd_run = 0, rd_last = 0, rd_pulses = 0;
  int cs_viol = 0, vld_cnt = 0, conv_left = 0;
  logic prev_wr = 1'b1;

  always #10 clk = ~clk;

  assign adc_data = (!rd_n && !cs_n) ? data_val : 8'hA5;

  adc_hs_ctrl #(
    .WR_LOW_CYC(WR_LOW_CYC), .RD_ACC_CYC(RD_ACC_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .adc_int_n_i(adc_int_n),
    .adc_data_i(adc_data), .adc_cs_n_o(cs_n), .adc_wr_n_o(wr_n),
    .adc_rd_n_o(rd_n), .result_o(result), .result_vld_o(vld),
    .busy_o(busy), .timeout_err_o(err)
  );

  // pin monitor and converter model
  always @(negedge clk) begin
    if (!wr_n) wr_run++;
    else if (wr_run != 0) begin wr_last = wr_run; wr_pulses++; wr_run = 0; end
    if (!rd_n) rd_run++;
    else if (rd_run != 0) begin rd_last = rd_run; rd_pulses++; rd_run = 0; end
    if ((!wr_n || !rd_n) && cs_n) cs_viol++;
    if (vld) vld_cnt++;
    if (!prev_wr && wr_n && !cs_n && adc_en) conv_left = conv_cycles;
    else if (conv_left > 0) begin
      conv_left--;
      if (conv_left == 0) adc_int_n = 1'b0;
    end
    if (!rd_n) adc_int_n = 1'b1;
    prev_wr = wr_n;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "cs_n in reset", int'(cs_n), 1);
    check("R1", "wr_n in reset", int'(wr_n), 1);
    check("R1", "rd_n in reset", int'(rd_n), 1);
    check("R1", "vld/busy/err in reset", int'({vld, busy, err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "idle after release", int'({cs_n, wr_n, rd_n, busy}), 14);
  endtask

  task automatic run_conv(logic [7:0] val, int conv, string name);
    int w0, v0, n;
    data_val = val; conv_cycles = conv; adc_en = 1'b1;
    w0 = wr_pulses; v0 = vld_cnt; n = 0;
    do_start();
    check("R7", {name, " busy after start"}, int'(busy), 1);
    while (!vld && !err && n < 20000) begin @(negedge clk); n++; end
    check("R6", {name, " valid seen"}, int'(vld), 1);
    check("R5", {name, " result"}, int'(result), int'(val));
    check("R6", {name, " rd/cs high in valid cycle"}, int'({rd_n, cs_n}), 3);
    check("R10", {name, " no error"}, int'(err), 0);
    @(negedge clk);
    check("R6", {name, " valid one cycle"}, int'(vld), 0);
    check("R7", {name, " busy drops"}, int'(busy), 0);
    check("R5", {name, " result held"}, int'(result), int'(val));
    check("R2", {name, " write low width"}, wr_last, WR_LOW_CYC);
    check("R4", {name, " read low width"}, rd_last, RD_ACC_CYC);
    check("R2", {name, " one write pulse"}, wr_pulses, w0 + 1);
    check("R6", {name, " one valid"}, vld_cnt, v0 + 1);
    check("R3", {name, " cs low on strobes"}, cs_viol, 0);
  endtask

  task automatic test_ignore();
    int w0, n;
    data_val = 8'h5A; conv_cycles = 200; w0 = wr_pulses; n = 0;
    do_start();
    for (int i = 0; i < 4; i++) begin
      repeat (10) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!vld && n < 20000) begin @(negedge clk); n++; end
    check("R5", "result after ignored starts", int'(result), 8'h5A);
    repeat (30) @(negedge clk);
    check("R8", "no extra write pulse", wr_pulses, w0 + 1);
    check("R8", "idle after ignored starts", int'(busy), 0);
  endtask

  task automatic test_timeout();
    int r0, v0, n;
    adc_en = 1'b0; r0 = rd_pulses; v0 = vld_cnt; n = 0;
    do_start();
    while (!err && n < TIMEOUT_CYC + 100) begin @(negedge clk); n++; end
    check("R10", "error pulse seen", int'(err), 1);
    check("R9", "wait lasted the full limit", int'(n >= TIMEOUT_CYC), 1);
    check("R10", "no read strobe", rd_pulses, r0);
    check("R10", "no valid", vld_cnt, v0);
    @(negedge clk);
    check("R10", "error one cycle", int'(err), 0);
    check("R10", "back to idle", int'({busy, cs_n}), 1);
    adc_en = 1'b1;
  endtask

  task automatic test_async_reset();
    conv_cycles = 300; data_val = 8'h11;
    do_start();
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1", "async reset pins", int'({cs_n, wr_n, rd_n, busy, vld}), 28);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (320) @(negedge clk);
    check("R1", "stays idle after mid-run reset", int'({busy, rd_n}), 1);
  endtask

  initial begin
    test_reset();
    run_conv(8'h3C, 50, "basic");
    run_conv(8'h00, 5, "zero");
    run_conv(8'hFF, 17, "full");
    test_ignore();
    run_conv(8'hC3, 5000, "slow");
    test_timeout();
    run_conv(8'h96, 30, "recover");
    test_async_reset();
    run_conv(8'h69, 12, "post-reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule